// File: doc/BRIEF.md
# Paged memory mapper with serial-bit control

This block sits between a 16-bit host CPU and a 512 KB external SRAM. It turns each CPU access into a 19-bit physical SRAM address. After reset it works as a flat 32 KB memory expansion. In that mode a CPU address inside one of the expansion windows is placed directly above a 256 KB base. Once translation is switched on, each 4 KB slice of the CPU address space is redirected to any of 64 physical pages within that 256 KB region.

The page-number table has no internal registers. It lives in a small area of the SRAM itself, at parameter `PT_BASE`. Every translated access therefore becomes two SRAM operations. The first reads the page number for the slice. The second performs the data read or write at the translated address. While page-register access is on, a small CPU window reaches the table entries directly.

Three control bits sit on a bit-addressed serial I/O (CRU) bus and can all be read back on one input line:

- the disk-driver ROM paging bit, which drives a select output;
- the page-register access enable;
- the translation enable.

The sequencer has five named states:

- `ST_IDLE` waits for a CPU request and classifies it.
- `ST_LOOKUP` reads the page number from the table.
- `ST_DATA` performs the data access.
- `ST_TABLE` reads or writes a table entry.
- `ST_DONE` returns the acknowledge pulse.

Its transitions are:

- `ST_IDLE` → `ST_TABLE` on a page-window request.
- `ST_IDLE` → `ST_LOOKUP` on a window request with translation on.
- `ST_IDLE` → `ST_DATA` on a window request with translation off.
- `ST_IDLE` → `ST_DONE` on any other request.
- `ST_LOOKUP` → `ST_DATA` on the SRAM acknowledge.
- `ST_DATA` → `ST_DONE` and `ST_TABLE` → `ST_DONE` on the SRAM acknowledge.
- `ST_DONE` → `ST_IDLE` unconditionally.

Top module: `paged_mapper`

## Requirements
- R1: After a synchronous reset, all three control bits are 0. `cru_rbit` reads 0 at the CRU addresses 0x1100, 0x1E00 and 0x1E02, `rom_page_en` is 0, and the mapper is in flat mode.
- R2: A CRU write with `cru_wen`=1 at 0x1100, 0x1E00 or 0x1E02 stores `cru_wbit` in the ROM-paging, page-access or translation bit respectively. `cru_rbit` returns the stored bit for the address on `cru_addr`, and `rom_page_en` follows the 0x1100 bit. At any other CRU address, reads return 0 and writes change no control bit.
- R3: With translation off, a CPU access in 0x2000–0x3FFF or 0xA000–0xFFFF makes exactly one SRAM operation, at physical 0x40000 + CPU address, with the CPU's read/write direction.
- R4: A CPU access outside the expansion windows makes no SRAM operation and is acknowledged with `cpu_rdata` = 0. This includes 0x4000–0x401F while page access is off.
- R5: With translation on, a window access makes two SRAM operations. The first is a read at `PT_BASE` + CPU address bits 15:12. The second is the data access at 0x40000 + (entry bits 5:0 × 4096) + CPU address bits 11:0. Entry bits 7:6 are ignored.
- R6: With page access on, a CPU access in 0x4000–0x401F makes one SRAM operation, a read or write of the table byte at `PT_BASE` + CPU address bits 4:1. This holds whether translation is on or off.
- R7: Physical bytes hidden under the CPU's I/O region, such as 0x49F7A, can be reached with translation on. For example, entry 10 = 0x09 and CPU address 0xAF7A give 0x49F7A.
- R8: `sram_req` and `sram_addr` stay stable until `sram_ack`. Each CPU request gets exactly one `cpu_ack`, lasting one cycle.
- R9: A synchronous reset while translation is on returns the mapper to flat mode. The next access to 0xA000 is a single SRAM operation at 0x4A000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | One-cycle CPU access request, accepted when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cru_wen | input | 1 | CRU bit write strobe |
| cru_addr | input | 16 | CRU bit address |
| cru_wbit | input | 1 | CRU write value |
| cru_rbit | output | 1 | CRU read value of the addressed bit |
| rom_page_en | output | 1 | Disk-driver ROM paging select |
| sram_req | output | 1 | SRAM operation request, held until ack |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 19 | SRAM physical byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, valid with sram_ack |
| sram_ack | input | 1 | SRAM operation complete |

## Verification
The bench builds the block with its defaults: a 16-bit CPU address, 12-bit page offset, 6-bit page number, 8-bit data and a table base of 0x3FFF0. These values put every one of the 64 physical pages and all 16 table entries within reach. Random table contents therefore send accesses anywhere in the 256 KB region, including the byte range hidden under the I/O region. Because the table sits below 0x40000, random data writes can never corrupt it. A wrong operation count or order shows up at once as a wrong SRAM address.

// File: rtl/paged_mapper_pkg.sv
package paged_mapper_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_DATA,
        ST_TABLE,
        ST_DONE
    } map_state_e;

    typedef struct packed {
        logic rom_page;
        logic preg_en;
        logic map_en;
    } map_ctl_t;

    localparam int NCTL = 3;

endpackage

// File: rtl/paged_mapper_cru.sv
module paged_mapper_cru
    import paged_mapper_pkg::*;
#(
    parameter int          AW       = 16,
    parameter logic [15:0] ROM_BIT  = 16'h1100,
    parameter logic [15:0] PREG_BIT = 16'h1E00,
    parameter logic [15:0] MAP_BIT  = 16'h1E02
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cru_wen,
    input  logic [AW-1:0] cru_addr,
    input  logic          cru_wbit,
    output logic          cru_rbit,
    output map_ctl_t      ctl
);

    logic [NCTL-1:0] bits_q;
    logic [NCTL-1:0] hit;

    function automatic logic [AW-1:0] bit_addr(input int i);
        case (i)
            0:       bit_addr = AW'(MAP_BIT);
            1:       bit_addr = AW'(PREG_BIT);
            default: bit_addr = AW'(ROM_BIT);
        endcase
    endfunction

    for (genvar i = 0; i < NCTL; i++) begin : g_bit
        assign hit[i] = (cru_addr == bit_addr(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q[i] <= 1'b0;
            end else if (cru_wen && hit[i]) begin
                bits_q[i] <= cru_wbit;
            end
        end
    end

    assign cru_rbit = |(hit & bits_q);
    assign ctl      = map_ctl_t'(bits_q);

    // R1
    ctl_reset_chk: assert property (@(posedge clk) $past(rst) |-> (ctl == '0));

    // R2
    map_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cru_wen && cru_addr == AW'(MAP_BIT)) |=> (ctl.map_en == $past(cru_wbit)));

    // R2
    other_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cru_wen && cru_addr != AW'(MAP_BIT) && cru_addr != AW'(PREG_BIT)
         && cru_addr != AW'(ROM_BIT)) |=> $stable(ctl));

endmodule

// File: rtl/paged_mapper_dec.sv
module paged_mapper_dec #(
    parameter int          AW        = 16,
    parameter int          OFFW      = 12,
    parameter int          IDXW      = AW - OFFW,
    parameter logic [15:0] LO_FIRST  = 16'h2000,
    parameter logic [15:0] LO_LAST   = 16'h3FFF,
    parameter logic [15:0] HI_FIRST  = 16'hA000,
    parameter logic [15:0] HI_LAST   = 16'hFFFF,
    parameter logic [15:0] PG_FIRST  = 16'h4000,
    parameter logic [15:0] PG_LAST   = 16'h401F
) (
    input  logic [AW-1:0]   addr,
    input  logic            preg_en,
    output logic            in_win,
    output logic            in_preg,
    output logic [IDXW-1:0] look_idx,
    output logic [IDXW-1:0] preg_idx,
    output logic [OFFW-1:0] offset
);

    logic lo_hit, hi_hit, pg_hit;

    always_comb begin
        lo_hit   = (addr >= AW'(LO_FIRST)) && (addr <= AW'(LO_LAST));
        hi_hit   = (addr >= AW'(HI_FIRST)) && (addr <= AW'(HI_LAST));
        pg_hit   = (addr >= AW'(PG_FIRST)) && (addr <= AW'(PG_LAST));
        in_win   = lo_hit || hi_hit;
        in_preg  = pg_hit && preg_en;
        look_idx = addr[AW-1:OFFW];
        preg_idx = addr[IDXW:1];
        offset   = addr[OFFW-1:0];
    end

endmodule

// File: rtl/paged_mapper.sv
module paged_mapper
    import paged_mapper_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          PW       = 19,
    parameter int          DW       = 8,
    parameter int          OFFW     = 12,
    parameter int          PGW      = 6,
    parameter logic [18:0] MAP_BASE = 19'h40000,
    parameter logic [18:0] PT_BASE  = 19'h3FFF0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_ack,
    input  logic          cru_wen,
    input  logic [AW-1:0] cru_addr,
    input  logic          cru_wbit,
    output logic          cru_rbit,
    output logic          rom_page_en,
    output logic          sram_req,
    output logic          sram_we,
    output logic [PW-1:0] sram_addr,
    output logic [DW-1:0] sram_wdata,
    input  logic [DW-1:0] sram_rdata,
    input  logic          sram_ack
);

    localparam int IDXW = AW - OFFW;

    map_state_e      state, nstate;
    map_ctl_t        ctl;
    logic [AW-1:0]   req_addr;
    logic [AW-1:0]   dec_addr;
    logic            req_we;
    logic            req_mapped;
    logic [DW-1:0]   req_wdata;
    logic [PGW-1:0]  page_q;
    logic [DW-1:0]   rdata_q;
    logic            in_win, in_preg;
    logic [IDXW-1:0] look_idx, preg_idx;
    logic [OFFW-1:0] offset;
    logic [PW-1:0]   xlat_addr, flat_addr;

    paged_mapper_cru #(.AW(AW)) u_cru (
        .clk      (clk),
        .rst      (rst),
        .cru_wen  (cru_wen),
        .cru_addr (cru_addr),
        .cru_wbit (cru_wbit),
        .cru_rbit (cru_rbit),
        .ctl      (ctl)
    );

    assign dec_addr = (state == ST_IDLE) ? cpu_addr : req_addr;

    paged_mapper_dec #(.AW(AW), .OFFW(OFFW), .IDXW(IDXW)) u_dec (
        .addr     (dec_addr),
        .preg_en  (ctl.preg_en),
        .in_win   (in_win),
        .in_preg  (in_preg),
        .look_idx (look_idx),
        .preg_idx (preg_idx),
        .offset   (offset)
    );

    assign rom_page_en = ctl.rom_page;
    assign xlat_addr   = PW'(MAP_BASE) | PW'({page_q, offset});
    assign flat_addr   = PW'(MAP_BASE) | PW'(req_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (in_preg)      nstate = ST_TABLE;
                    else if (in_win)  nstate = ctl.map_en ? ST_LOOKUP : ST_DATA;
                    else              nstate = ST_DONE;
                end
            end
            ST_LOOKUP: if (sram_ack) nstate = ST_DATA;
            ST_DATA:   if (sram_ack) nstate = ST_DONE;
            ST_TABLE:  if (sram_ack) nstate = ST_DONE;
            ST_DONE:   nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_addr   <= '0;
            req_we     <= 1'b0;
            req_mapped <= 1'b0;
            req_wdata  <= '0;
            page_q     <= '0;
            rdata_q    <= '0;
        end else begin
            if (state == ST_IDLE && cpu_req) begin
                req_addr   <= cpu_addr;
                req_we     <= cpu_we;
                req_mapped <= ctl.map_en;
                req_wdata  <= cpu_wdata;
                rdata_q    <= '0;
            end
            if (state == ST_LOOKUP && sram_ack) begin
                page_q <= sram_rdata[PGW-1:0];
            end
            if ((state == ST_DATA || state == ST_TABLE) && sram_ack && !req_we) begin
                rdata_q <= sram_rdata;
            end
        end
    end

    always_comb begin
        sram_req   = 1'b0;
        sram_we    = 1'b0;
        sram_addr  = '0;
        sram_wdata = req_wdata;
        cpu_ack    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOOKUP: begin
                sram_req  = 1'b1;
                sram_addr = PW'(PT_BASE) + PW'(look_idx);
            end
            ST_DATA: begin
                sram_req  = 1'b1;
                sram_we   = req_we;
                sram_addr = req_mapped ? xlat_addr : flat_addr;
            end
            ST_TABLE: begin
                sram_req  = 1'b1;
                sram_we   = req_we;
                sram_addr = PW'(PT_BASE) + PW'(preg_idx);
            end
            ST_DONE: cpu_ack = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rdata = rdata_q;

    // R8
    sram_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sram_req && !sram_ack) |=> (sram_req && $stable(sram_addr) && $stable(sram_we)));

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);

    // R5
    lookup_then_data_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOKUP && sram_ack) |=> (state == ST_DATA && sram_req && !$past(sram_we)));

    // R3
    data_region_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && sram_req) |-> (sram_addr >= PW'(MAP_BASE)));

    // R6
    table_region_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TABLE) |-> (sram_addr >= PW'(PT_BASE) && sram_addr < PW'(PT_BASE) + PW'(2**IDXW)));

endmodule

// File: tb/paged_mapper_tb.sv
module paged_mapper_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [18:0] PTB = 19'h3FFF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ack;
    logic        cru_wen = 1'b0;
    logic [15:0] cru_addr = '0;
    logic        cru_wbit = 1'b0;
    logic        cru_rbit, rom_page_en;
    logic        sram_req, sram_we;
    logic [18:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic [7:0]  sram_rdata = '0;
    logic        sram_ack = 1'b0;

    int nvec = 0, nfail = 0;
    int op_total = 0;
    logic [18:0] op_addr [4];
    logic        op_we   [4];

    logic [7:0] mem     [0:524287];
    logic [7:0] ref_mem [0:524287];
    logic [7:0] pt [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_mapper u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .cru_wen(cru_wen), .cru_addr(cru_addr), .cru_wbit(cru_wbit),
        .cru_rbit(cru_rbit), .rom_page_en(rom_page_en),
        .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .sram_ack(sram_ack)
    );

    always @(posedge clk) begin
        if (rst) begin
            sram_ack <= 1'b0;
        end else if (sram_req && !sram_ack) begin
            sram_ack <= 1'b1;
            if (sram_we) mem[sram_addr] <= sram_wdata;
            else         sram_rdata <= mem[sram_addr];
            op_addr[op_total % 4] <= sram_addr;
            op_we[op_total % 4]   <= sram_we;
            op_total <= op_total + 1;
        end else begin
            sram_ack <= 1'b0;
        end
    end

    function automatic logic [7:0] pat(input int i);
        pat = 8'(i) ^ 8'(i >> 8) ^ 8'(i >> 16) ^ 8'h5A;
    endfunction

    function automatic logic in_win(input logic [15:0] a);
        in_win = (a >= 16'h2000 && a <= 16'h3FFF) || (a >= 16'hA000);
    endfunction

    function automatic logic [18:0] exp_phys(input logic [15:0] a, input logic mapped);
        if (mapped) exp_phys = 19'h40000 | {1'b0, pt[a[15:12]][5:0], a[11:0]};
        else        exp_phys = 19'h40000 | {3'b000, a};
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int          n_ops;
    logic [7:0]  rd;
    logic [18:0] a0, a1;
    logic        w1;

    task automatic cpu_access(input logic we, input logic [15:0] a, input logic [7:0] wd);
        int start;
        int k;
        @(negedge clk);
        start = op_total;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        k = 0;
        while (!cpu_ack && k < 30) begin
            @(negedge clk);
            k++;
        end
        chk(cpu_ack, "R8 ack", 32'(cpu_ack), 1);
        rd    = cpu_rdata;
        n_ops = op_total - start;
        a0    = op_addr[start % 4];
        a1    = op_addr[(start + 1) % 4];
        w1    = op_we[(start + n_ops - 1) % 4];
        @(negedge clk);
        chk(!cpu_ack, "R8 ack pulse", 32'(cpu_ack), 0);
    endtask

    task automatic cru_write(input logic [15:0] a, input logic b);
        @(negedge clk);
        cru_wen = 1'b1; cru_addr = a; cru_wbit = b;
        @(negedge clk);
        cru_wen = 1'b0;
    endtask

    task automatic cru_check(input logic [15:0] a, input logic b, input string tag);
        @(negedge clk);
        cru_addr = a;
        #1;
        chk(cru_rbit == b, tag, 32'(cru_rbit), 32'(b));
    endtask

    task automatic flat_check(input logic we, input logic [15:0] a, input string tag);
        logic [7:0]  wd;
        logic [18:0] p;
        wd = 8'($urandom);
        p  = exp_phys(a, 1'b0);
        cpu_access(we, a, wd);
        chk(n_ops == 1, {tag, " ops"}, n_ops, 1);
        chk(a0 == p, {tag, " addr"}, 32'(a0), 32'(p));
        chk(w1 == we, {tag, " dir"}, 32'(w1), 32'(we));
        if (we) ref_mem[p] = wd;
        else chk(rd == ref_mem[p], {tag, " data"}, 32'(rd), 32'(ref_mem[p]));
    endtask

    task automatic mapped_check(input logic we, input logic [15:0] a, input string tag);
        logic [7:0]  wd;
        logic [18:0] p;
        wd = 8'($urandom);
        p  = exp_phys(a, 1'b1);
        cpu_access(we, a, wd);
        chk(n_ops == 2, {tag, " ops"}, n_ops, 2);
        chk(a0 == PTB + 19'(a[15:12]), {tag, " lookup addr"}, 32'(a0), 32'(PTB + 19'(a[15:12])));
        chk(a1 == p, {tag, " data addr"}, 32'(a1), 32'(p));
        if (we) ref_mem[p] = wd;
        else chk(rd == ref_mem[p], {tag, " data"}, 32'(rd), 32'(ref_mem[p]));
    endtask

    task automatic preg_access(input logic we, input int idx, input logic [7:0] wd, input string tag);
        logic [18:0] p;
        p = PTB + 19'(idx);
        cpu_access(we, 16'h4000 + 16'(idx * 2), wd);
        chk(n_ops == 1, {tag, " ops"}, n_ops, 1);
        chk(a0 == p, {tag, " addr"}, 32'(a0), 32'(p));
        if (we) begin
            ref_mem[p] = wd;
            pt[idx]    = wd;
        end else begin
            chk(rd == ref_mem[p], {tag, " data"}, 32'(rd), 32'(ref_mem[p]));
        end
    endtask

    task automatic null_check(input logic [15:0] a, input string tag);
        cpu_access(1'b0, a, 8'h00);
        chk(n_ops == 0, {tag, " ops"}, n_ops, 0);
        chk(rd == 8'h00, {tag, " data"}, 32'(rd), 0);
    endtask

    function automatic logic [15:0] rand_win();
        logic [31:0] r;
        r = $urandom;
        if (r[31]) rand_win = {3'b001, r[12:0]};
        else       rand_win = 16'hA000 + 16'(r[23:0] % 32'h6000);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h0005EED1));
        for (int i = 0; i < 524288; i++) begin
            mem[i]     = pat(i);
            ref_mem[i] = pat(i);
        end
        for (int i = 0; i < 16; i++) pt[i] = ref_mem[PTB + 19'(i)];

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        cru_check(16'h1100, 1'b0, "R1 rom bit");
        cru_check(16'h1E00, 1'b0, "R1 page access bit");
        cru_check(16'h1E02, 1'b0, "R1 translation bit");
        chk(rom_page_en == 1'b0, "R1 rom_page_en", 32'(rom_page_en), 0);

        // R3: flat mode
        flat_check(1'b0, 16'h2000, "R3 flat low first");
        flat_check(1'b1, 16'hA123, "R3 flat write");
        flat_check(1'b0, 16'hA123, "R3 flat readback");
        flat_check(1'b0, 16'hFFFF, "R3 flat top");
        flat_check(1'b0, 16'h3FFF, "R3 flat low last");

        // R4: outside windows
        null_check(16'h1FFF, "R4 below window");
        null_check(16'h8000, "R4 mid gap");
        null_check(16'h4000, "R4 page window while disabled");
        null_check(16'h9FFF, "R4 gap end");

        // R2: control bit access
        cru_write(16'h1100, 1'b1);
        cru_check(16'h1100, 1'b1, "R2 rom bit set");
        chk(rom_page_en == 1'b1, "R2 rom_page_en", 32'(rom_page_en), 1);
        cru_write(16'h1102, 1'b1);
        cru_check(16'h1102, 1'b0, "R2 unused address reads 0");
        cru_check(16'h1E00, 1'b0, "R2 unused write left page bit");
        cru_check(16'h1E02, 1'b0, "R2 unused write left map bit");
        cru_write(16'h1100, 1'b0);
        cru_check(16'h1100, 1'b0, "R2 rom bit clear");
        cru_write(16'h1E00, 1'b1);
        cru_check(16'h1E00, 1'b1, "R2 page access bit");
        flat_check(1'b0, 16'hB000, "R2 translation still off");

        // R6: page table through the register window
        for (int i = 0; i < 16; i++) preg_access(1'b1, i, 8'($urandom), "R6 entry write");
        for (int i = 0; i < 16; i++) preg_access(1'b0, i, 8'h00, "R6 entry read");

        // R7: hidden byte reached through translation
        preg_access(1'b1, 10, 8'hC9, "R7 entry 10");
        cru_write(16'h1E02, 1'b1);
        cru_check(16'h1E02, 1'b1, "R2 translation bit");
        mapped_check(1'b0, 16'hAF7A, "R7 hidden byte");
        chk(a1 == 19'h49F7A, "R7 physical", 32'(a1), 32'h49F7A);

        // R5: random translated traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'h0) preg_access(1'b1, int'(r[11:8]), 8'(r[23:16]), "R5 remap");
            else mapped_check(r[4], rand_win(), "R5 translated");
        end
        null_check(16'h6000, "R4 gap with translation");

        // R6 with translation off
        cru_write(16'h1E02, 1'b0);
        preg_access(1'b0, 3, 8'h00, "R6 table read, translation off");
        for (int n = 0; n < 40; n++) begin
            logic [31:0] r;
            r = $urandom;
            flat_check(r[0], rand_win(), "R3 random flat");
        end

        // R9: reset with translation on
        cru_write(16'h1E02, 1'b1);
        cru_write(16'h1100, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cru_check(16'h1E02, 1'b0, "R9 translation cleared");
        cru_check(16'h1E00, 1'b0, "R9 page access cleared");
        cru_check(16'h1100, 1'b0, "R9 rom bit cleared");
        flat_check(1'b0, 16'hA000, "R9 flat after reset");
        chk(a0 == 19'h4A000, "R9 physical", 32'(a0), 32'h4A000);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule